// File: doc/BRIEF.md
# Eight-Queue Transmit Arbiter

This block decides which of eight transmit queues sends its next packet. Each queue raises a request line while it has work waiting. Decisions are made only at packet boundaries. When no packet is in flight and at least one request is present, the arbiter picks a winner, registers it, and shows it as a one-hot grant vector and a 3-bit channel index. The grant then stays fixed until the packet engine reports completion with a single-cycle done pulse.

A mode input picks the arbitration scheme at run time. In strict-priority mode the highest-numbered requesting channel wins. In rotating mode the search moves upward through the channel numbers and wraps from 7 to 0. It starts at the channel just above the one granted most recently. The mode is sampled only when a decision is taken, so a change while a packet is in flight has no effect on that packet.

Top module: `txq_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gnt_o` is all zeros and `gnt_valid_o` is 0.
- R2: In strict mode (`mode_rr_i` = 0), the grant goes to the highest-numbered channel whose `req_i` bit is 1. Bit n of `req_i` and of `gnt_o` stands for channel n.
- R3: In rotating mode (`mode_rr_i` = 1), the grant goes to the first requesting channel found when searching upward from the rotation pointer and wrapping from 7 to 0.
- R4: Every grant, in either mode, sets the rotation pointer to the granted index plus one, modulo 8.
- R5: Once granted, `gnt_o` and `gnt_idx_o` keep their values, whatever `req_i` does, until `done_i` is sampled high.
- R6: `done_i` sampled high during a grant clears the grant at that clock edge. The next grant appears no earlier than the edge after that.
- R7: With `req_i` all zero and no grant active, `gnt_valid_o` stays 0 and `gnt_o` stays all zero.
- R8: A change of `mode_rr_i` during a grant does not alter that grant. The new mode applies at the next decision.
- R9: `done_i` sampled while no grant is active is ignored.
- R10: `gnt_o` equals the one-hot code of `gnt_idx_o` while `gnt_valid_o` is 1.
- R11: After reset the rotation pointer is 0, so the first rotating-mode decision searches channel 0 first.
- R12: A decision is taken at the first clock edge at which no grant is active and `req_i` is nonzero. The grant is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rr_i | input | 1 | 0 = strict priority, 1 = rotating |
| req_i | input | 8 | Per-queue pending request |
| done_i | input | 1 | Pulse: granted packet finished |
| gnt_o | output | 8 | One-hot grant |
| gnt_valid_o | output | 1 | A grant is active |
| gnt_idx_o | output | 3 | Index of the granted channel |

## Verification
The assertions assume that `done_i` comes from the packet engine as a pulse. They tolerate `done_i` while idle, which is defined to be ignored. They also assume that request and mode inputs are steady around the clock edge. The bench changes every input only at the falling edge, so each decision sees settled values. It pulses done for exactly one cycle after each grant, except in the directed cases that deliberately hold requests, flip the mode, or pulse done while idle.

// File: rtl/txq_arb_pkg.sv
package txq_arb_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned IDX_W  = $clog2(NUM_CH);

  typedef logic [NUM_CH-1:0] chvec_t;
  typedef logic [IDX_W-1:0]  chidx_t;

  // highest set bit wins; returns 0 when vector is empty
  function automatic chidx_t top_set_bit(input chvec_t v);
    chidx_t r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (v[i]) r = chidx_t'(i);
    end
    return r;
  endfunction

  // lowest set bit; returns 0 when vector is empty
  function automatic chidx_t low_set_bit(input chvec_t v);
    chidx_t r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = chidx_t'(i);
    end
    return r;
  endfunction

  // rotate right so bit 'sh' lands at position 0
  function automatic chvec_t rot_down(input chvec_t v, input chidx_t sh);
    chvec_t r;
    for (int i = 0; i < NUM_CH; i++) begin
      r[i] = v[(i + int'(sh)) % NUM_CH];
    end
    return r;
  endfunction

  function automatic chidx_t idx_add(input chidx_t a, input chidx_t b);
    return chidx_t'((int'(a) + int'(b)) % NUM_CH);
  endfunction

  function automatic chvec_t one_hot(input chidx_t i);
    chvec_t r;
    r = '0;
    r[i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/txq_fixed_pick.sv
module txq_fixed_pick
  import txq_arb_pkg::*;
(
  input  chvec_t req_i,
  output chidx_t idx_o
);
  assign idx_o = top_set_bit(req_i);
endmodule

// File: rtl/txq_rr_pick.sv
module txq_rr_pick
  import txq_arb_pkg::*;
(
  input  chvec_t req_i,
  input  chidx_t start_i,
  output chidx_t idx_o
);
  chvec_t rotated;
  chidx_t offset;

  assign rotated = rot_down(req_i, start_i);
  assign offset  = low_set_bit(rotated);
  assign idx_o   = idx_add(start_i, offset);
endmodule

// File: rtl/txq_grant_ctrl.sv
module txq_grant_ctrl
  import txq_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   any_req_i,
  input  logic   done_i,
  input  chidx_t pick_i,
  output logic   busy_o,
  output chidx_t idx_o,
  output chidx_t ptr_o,
  output logic   decide_o,
  output logic   release_o
);
  assign decide_o  = !busy_o && any_req_i;
  assign release_o = busy_o && done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      ptr_o  <= '0;
    end else if (decide_o) begin
      busy_o <= 1'b1;
      idx_o  <= pick_i;
      ptr_o  <= idx_add(pick_i, chidx_t'(1));
    end else if (release_o) begin
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/txq_arbiter.sv
module txq_arbiter
  import txq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_rr_i,
  input  logic [7:0]       req_i,
  input  logic             done_i,
  output logic [7:0]       gnt_o,
  output logic             gnt_valid_o,
  output logic [2:0]       gnt_idx_o
);
  chidx_t fixed_idx_w;
  chidx_t rr_idx_w;
  chidx_t pick_w;
  chidx_t held_idx_w;
  chidx_t rr_ptr_w;
  logic   busy_w;
  logic   decide_w;
  logic   release_w;
  logic   any_req_w;

  assign any_req_w = |req_i;

  txq_fixed_pick u_fixed (
    .req_i (req_i),
    .idx_o (fixed_idx_w)
  );

  txq_rr_pick u_rr (
    .req_i   (req_i),
    .start_i (rr_ptr_w),
    .idx_o   (rr_idx_w)
  );

  // mode only matters when a decision is taken
  assign pick_w = mode_rr_i ? rr_idx_w : fixed_idx_w;

  txq_grant_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req_i (any_req_w),
    .done_i    (done_i),
    .pick_i    (pick_w),
    .busy_o    (busy_w),
    .idx_o     (held_idx_w),
    .ptr_o     (rr_ptr_w),
    .decide_o  (decide_w),
    .release_o (release_w)
  );

  assign gnt_valid_o = busy_w;
  assign gnt_idx_o   = held_idx_w;
  assign gnt_o       = busy_w ? one_hot(held_idx_w) : '0;
endmodule

// File: rtl/txq_arbiter_chk.sv
module txq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_rr_i,
  input logic [7:0] req_i,
  input logic       done_i,
  input logic [7:0] gnt_o,
  input logic       gnt_valid_o,
  input logic [2:0] gnt_idx_o,
  input logic       decide_w,
  input logic       release_w
);
  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> ($countones(gnt_o) == 1 && gnt_o[gnt_idx_o]));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && req_i == 8'h00) |=> !gnt_valid_o && gnt_o == 8'h00);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !done_i) |=> gnt_valid_o && $stable(gnt_idx_o));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> !gnt_valid_o);

  // R12
  decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide_w |=> gnt_valid_o && ((gnt_o & $past(req_i)) != 8'h00));

  // R2
  strict_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_w && !mode_rr_i) |=> ((($past(req_i) >> gnt_idx_o) >> 1) == 8'h00));

  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && done_i && req_i == 8'h00) |=> !gnt_valid_o);
endmodule

bind txq_arbiter txq_arbiter_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_rr_i   (mode_rr_i),
  .req_i       (req_i),
  .done_i      (done_i),
  .gnt_o       (gnt_o),
  .gnt_valid_o (gnt_valid_o),
  .gnt_idx_o   (gnt_idx_o),
  .decide_w    (decide_w),
  .release_w   (release_w)
);

// File: tb/txq_arbiter_tb.sv
module txq_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {mode, req[7:0], expected idx[2:0]}, sequence-dependent (pointer carries)
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 8'b1010_0110, 3'd7},  // R2
    {1'b0, 8'b0000_0110, 3'd2},  // R2, ptr->3
    {1'b1, 8'b0000_0110, 3'd1},  // R3 wrap, R4
    {1'b1, 8'b1000_0101, 3'd2},
    {1'b1, 8'b1000_0101, 3'd7},
    {1'b1, 8'b1000_0101, 3'd0},
    {1'b1, 8'b1111_1111, 3'd1},
    {1'b1, 8'b0000_0010, 3'd1},
    {1'b0, 8'b0000_0001, 3'd0},
    {1'b1, 8'b0000_0001, 3'd0},
    {1'b0, 8'b0101_0000, 3'd6},  // ptr->7
    {1'b1, 8'b1000_0001, 3'd7}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_rr_i = 1'b0;
  logic [7:0] req_i = 8'h00;
  logic       done_i = 1'b0;
  logic [7:0] gnt_o;
  logic       gnt_valid_o;
  logic [2:0] gnt_idx_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_arbiter dut_i (
    .clk (clk), .rst_n (rst_n), .mode_rr_i (mode_rr_i), .req_i (req_i),
    .done_i (done_i), .gnt_o (gnt_o), .gnt_valid_o (gnt_valid_o),
    .gnt_idx_o (gnt_idx_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_grant(input string tag, input int idx);
    check({tag, " valid"}, int'(gnt_valid_o), 1);
    check({tag, " idx"}, int'(gnt_idx_o), idx);
    check({tag, " onehot R10"}, int'(gnt_o), 1 << idx);
  endtask

  task automatic finish_pkt();
    done_i = 1'b1; req_i = 8'h00;
    @(negedge clk);
    done_i = 1'b0;
    check("R6 grant cleared", int'(gnt_valid_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!finished) begin
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(gnt_valid_o), 0);
    check("R1 gnt in reset", int'(gnt_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gnt after reset", int'(gnt_o), 0);

    // R11: first rotating search starts at 0
    mode_rr_i = 1'b1; req_i = 8'hFF;
    @(negedge clk);
    check_grant("R11 first rr", 0);
    finish_pkt();

    // reset again so the table starts with pointer 0
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      mode_rr_i = VEC[v][11];
      req_i = VEC[v][10:3];
      @(negedge clk);
      check_grant($sformatf("R2/R3/R4/R12 vec%0d", v), int'(VEC[v][2:0]));
      finish_pkt();
      // R7: no requests, nothing granted
      @(negedge clk);
      check("R7 idle", int'(gnt_valid_o), 0);
    end

    // R5: hold while requests change (pointer now 0)
    mode_rr_i = 1'b0; req_i = 8'h08;
    @(negedge clk);
    check_grant("R5 start", 3);
    req_i = 8'h80;
    @(negedge clk);
    req_i = 8'h01;
    @(negedge clk);
    check_grant("R5 held", 3);

    // R8: mode flip mid-packet, ptr=4
    mode_rr_i = 1'b1;
    @(negedge clk);
    check_grant("R8 held after flip", 3);
    // R6: done with request still present: one idle cycle, then regrant
    req_i = 8'h81; done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    check("R6 gap", int'(gnt_valid_o), 0);
    @(negedge clk);
    check_grant("R8 rr applies next", 7);  // from 4 upward
    finish_pkt();

    // R9: done while idle ignored, then normal decision
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    check("R9 idle done", int'(gnt_valid_o), 0);
    mode_rr_i = 1'b1; req_i = 8'h03;   // ptr 0
    @(negedge clk);
    check_grant("R9 next grant", 0);
    done_i = 1'b1;  // real done
    @(negedge clk);
    done_i = 1'b0;
    @(negedge clk);
    check_grant("R4 after 0 goes to 1", 1);
    finish_pkt();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule